// File: doc/BRIEF.md
# Four-State Strap Address Decoder

This block derives a 7-bit I2C target address from two strap pins. Each strap can be wired to the supply, to ground, to the SDA wire or to the SCL wire. That gives four states per pin and sixteen addresses in all. The block watches the already-synchronized bus lines. On every START condition it works out what each strap is wired to, whichever device the transfer is meant for. Changing the strap wiring at run time therefore moves the address at the next transfer, with no power cycle.

Classification has two steps. At the START edge, a strap that was low while SDA was still high is grounded. A strap that was high and then drops together with SDA is SDA-tied. A strap that stays high is held as pending. At the first SCL fall after that START, a pending strap that is still high is supply-tied, and one that follows SCL low is SCL-tied. The result is committed at that SCL fall. Before the first commit, a strap can only be read as high or low. In that state a high pin counts as supply and a low pin counts as ground.

The same classification also drives one pullup-group enable per strap. Each enable switches on pullups for one group of four input ports.

Top module: `strap_addr_decoder`

## Requirements
- R1: After reset, `decoded_valid_o` is 0.
- R2: While `decoded_valid_o` is 0, each strap is read statically. A high pin gives tie code 1 (supply) and a low pin gives tie code 0 (ground). The reading follows the pin one cycle late.
- R3: A strap that is low in the cycle before SDA falls at a START is classified as ground, tie code 0.
- R4: A strap that is high at the START and still high at the next SCL fall is classified as supply, tie code 1.
- R5: A strap that is high at the START and low at the next SCL fall is classified as SCL-tied, tie code 2.
- R6: A strap that is high in the cycle before the START and low in the START cycle is classified as SDA-tied, tie code 3.
- R7: `addr_o[6:4]` equals parameter `ADDR_HI`. `addr_o[3:2]` is the tie code of strap B and `addr_o[1:0]` is the tie code of strap A.
- R8: `pullup_en_o[k]` is bit 0 of the tie code of strap k (bit 0 = strap A, bit 1 = strap B), so a group is on for supply or SDA ties.
- R9: `decoded_valid_o` rises one cycle after the first commit, meaning the first SCL fall after a START. It then stays high until reset.
- R10: Every START is decoded again. A strap change made between transfers appears on the outputs one cycle after the SCL fall that follows the next START.
- R11: Once valid, the outputs keep their value between commits, whatever the strap pins do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sda_i | input | 1 | Synchronized SDA level |
| scl_i | input | 1 | Synchronized SCL level |
| strap_a_i | input | 1 | Strap pin A level |
| strap_b_i | input | 1 | Strap pin B level |
| addr_o | output | 7 | Decoded target address |
| pullup_en_o | output | 2 | Pullup-group enables, one per strap |
| decoded_valid_o | output | 1 | High once a START has been classified |

## Verification
The bench builds the block with its default two straps and sets `ADDR_HI` to 3'b101. The fixed upper bits can then be told apart from the strap-driven lower bits. This small configuration lets the bench sweep all sixteen strap pairings through live START/SCL sequences, and every supply and ground pairing in the static pre-decode state. The bench also moves the straps between transfers. This shows that the outputs hold until the next START is classified and then switch.

// File: rtl/strap_pkg.sv
package strap_pkg;
  localparam int TIE_W = 2;
  localparam logic [TIE_W-1:0] TIE_GND = 2'd0;
  localparam logic [TIE_W-1:0] TIE_VDD = 2'd1;
  localparam logic [TIE_W-1:0] TIE_SCL = 2'd2;
  localparam logic [TIE_W-1:0] TIE_SDA = 2'd3;
endpackage

// File: rtl/bus_event_det.sv
module bus_event_det (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sda_i,
  input  logic scl_i,
  output logic start_o,
  output logic scl_fall_o
);
  logic sda_q, scl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sda_q <= 1'b1;
      scl_q <= 1'b1;
    end else begin
      sda_q <= sda_i;
      scl_q <= scl_i;
    end
  end

  assign start_o    = sda_q & ~sda_i & scl_q & scl_i;
  assign scl_fall_o = scl_q & ~scl_i;
endmodule

// File: rtl/strap_classifier.sv
module strap_classifier
  import strap_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             pin_i,
  output logic [TIE_W-1:0] cand_o,
  output logic [TIE_W-1:0] static_o
);
  logic             pin_q;
  logic             pend_q;
  logic [TIE_W-1:0] tent_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pin_q  <= 1'b0;
      pend_q <= 1'b0;
      tent_q <= TIE_GND;
    end else begin
      pin_q <= pin_i;
      if (start_i) begin
        // pin_q holds the level from before SDA fell
        if (!pin_q) begin
          tent_q <= TIE_GND;
          pend_q <= 1'b0;
        end else if (!pin_i) begin
          tent_q <= TIE_SDA;
          pend_q <= 1'b0;
        end else begin
          tent_q <= TIE_VDD;
          pend_q <= 1'b1;
        end
      end
    end
  end

  // pending pins are split on the SCL-low sample at commit time
  assign cand_o   = pend_q ? (pin_i ? TIE_VDD : TIE_SCL) : tent_q;
  assign static_o = pin_q ? TIE_VDD : TIE_GND;
endmodule

// File: rtl/strap_addr_decoder.sv
module strap_addr_decoder
  import strap_pkg::*;
#(
  parameter logic [2:0] ADDR_HI = 3'b110
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       sda_i,
  input  logic       scl_i,
  input  logic       strap_a_i,
  input  logic       strap_b_i,
  output logic [6:0] addr_o,
  output logic [1:0] pullup_en_o,
  output logic       decoded_valid_o
);
  localparam int N_STRAP = 2;
  localparam int LOW_W   = N_STRAP * TIE_W;

  logic start, scl_fall, commit;
  logic armed_q, valid_q;
  logic [N_STRAP-1:0] pins;
  logic [TIE_W-1:0] cand [N_STRAP];
  logic [TIE_W-1:0] stat [N_STRAP];
  logic [TIE_W-1:0] cls_q [N_STRAP];
  logic [TIE_W-1:0] sel [N_STRAP];
  logic [LOW_W-1:0] low;

  assign pins = {strap_b_i, strap_a_i};

  bus_event_det u_evt (
    .clk_i, .rst_ni, .sda_i, .scl_i,
    .start_o(start), .scl_fall_o(scl_fall)
  );

  assign commit = armed_q & scl_fall;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      armed_q <= 1'b0;
      valid_q <= 1'b0;
    end else begin
      if (start) armed_q <= 1'b1;
      else if (commit) armed_q <= 1'b0;
      if (commit) valid_q <= 1'b1;
    end
  end

  for (genvar k = 0; k < N_STRAP; k++) begin : g_strap
    strap_classifier u_cls (
      .clk_i, .rst_ni, .start_i(start), .pin_i(pins[k]),
      .cand_o(cand[k]), .static_o(stat[k])
    );

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) cls_q[k] <= TIE_GND;
      else if (commit) cls_q[k] <= cand[k];
    end

    assign sel[k] = valid_q ? cls_q[k] : stat[k];
    assign low[k*TIE_W +: TIE_W] = sel[k];
    assign pullup_en_o[k] = sel[k][0];
  end

  assign addr_o          = {ADDR_HI, low};
  assign decoded_valid_o = valid_q;

  a_r9_valid_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    decoded_valid_o |=> decoded_valid_o);
  a_r9_commit_sets_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit |=> decoded_valid_o);
  a_r10_start_arms: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start |=> armed_q);
  a_r11_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_q && !commit) |=> $stable(addr_o));
  a_r7_upper_const: assert property (@(posedge clk_i) disable iff (!rst_ni)
    decoded_valid_o |-> (addr_o[6:4] == ADDR_HI));
endmodule

// File: tb/strap_addr_decoder_bench.sv
module strap_addr_decoder_bench;
  localparam logic [2:0] HI = 3'b101;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic sda = 1'b1, scl = 1'b1;
  logic [1:0] sel_a = 2'd0, sel_b = 2'd0;
  logic pa, pb;
  logic [6:0] addr;
  logic [1:0] pu;
  logic valid;
  int n_run = 0, n_fail = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  function automatic logic tie_lvl(logic [1:0] s, logic d, logic c);
    case (s)
      2'd0: return 1'b0;
      2'd1: return 1'b1;
      2'd2: return c;
      default: return d;
    endcase
  endfunction

  assign pa = tie_lvl(sel_a, sda, scl);
  assign pb = tie_lvl(sel_b, sda, scl);

  strap_addr_decoder #(.ADDR_HI(HI)) u_strap_addr_decoder (
    .clk_i(clk), .rst_ni(rst_ni), .sda_i(sda), .scl_i(scl),
    .strap_a_i(pa), .strap_b_i(pb),
    .addr_o(addr), .pullup_en_o(pu), .decoded_valid_o(valid)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic chk_out(string req, logic [1:0] ea, logic [1:0] eb);
    chk(req, {25'd0, addr}, {25'd0, HI, eb, ea});
    chk({req, "/R8"}, {30'd0, pu}, {30'd0, eb[0], ea[0]});
  endtask

  task automatic txn();
    @(negedge clk); sda = 1'b0;
    repeat (3) @(negedge clk); scl = 1'b0;
    repeat (3) @(negedge clk); scl = 1'b1;
    repeat (2) @(negedge clk); sda = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1", {31'd0, valid}, 32'd0);
    rst_ni = 1'b1;
    // R2: static reading before the first START
    for (int i = 0; i < 4; i++) begin
      @(negedge clk); sel_a = {1'b0, i[0]}; sel_b = {1'b0, i[1]};
      repeat (2) @(negedge clk);
      chk_out("R2", sel_a, sel_b);
    end
    @(negedge clk); sel_a = 2'd3; sel_b = 2'd0;
    repeat (2) @(negedge clk);
    chk_out("R2 sda-tied reads supply", 2'd1, 2'd0);
    chk("R1", {31'd0, valid}, 32'd0);
    // R3-R6: full sweep of strap pairings
    for (int i = 0; i < 16; i++) begin
      @(negedge clk); sel_a = i[1:0]; sel_b = i[3:2];
      repeat (2) @(negedge clk);
      txn();
      chk_out("R3/R4/R5/R6/R7", sel_a, sel_b);
      chk("R9", {31'd0, valid}, 32'd1);
    end
    // R11 then R10: strap change between transfers
    @(negedge clk); sel_a = 2'd2; sel_b = 2'd3;
    repeat (2) @(negedge clk);
    txn();
    chk_out("R10", 2'd2, 2'd3);
    @(negedge clk); sel_a = 2'd1; sel_b = 2'd0;
    repeat (5) @(negedge clk);
    chk_out("R11", 2'd2, 2'd3);
    txn();
    chk_out("R10", 2'd1, 2'd0);
    chk("R9", {31'd0, valid}, 32'd1);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule